// File: doc/BRIEF.md
# SECDED 72/64 Memory ECC Codec

This block protects a 64-bit memory word with eight check bits. On the write side a purely combinational generator turns the data into its check byte. Each check bit is the parity of the data bits whose matrix column has that bit set. Every data bit has a fixed odd-weight column of weight three or five, and every check bit has a one-hot column. No two columns are equal.

On the read side the block takes the stored 72-bit word, recomputes the check byte and XORs it with the stored one to form the syndrome. It classifies the syndrome, repairs a single flipped data bit, and reports the result one clock later. The outputs are the corrected data, the syndrome, a correctable flag, an uncorrectable flag and the position of the repaired bit. A parameter can remove the output register so that the read path becomes combinational.

Top module: `secded_codec`

## Requirements
- R1: `wr_check_o` bit j equals the XOR of every data bit i of `wr_data_i` whose column has bit j set. The column of data bit i, for i = 0 up to 63, is entry i of the fixed column table: f4 f1 ec ea e9 e6 e5 e3 dc da d9 d6 d5 d3 ce cb b5 b0 ad ab a8 a7 a4 a2 9d 9b 98 97 94 92 8f 8a 75 70 6d 6b 68 67 64 62 5e 5b 58 57 54 52 4f 4a 34 31 2c 2a 29 26 25 23 1c 1a 19 16 15 13 0e 0b (hex). The check bit is combinational, with no latency.
- R2: `dec_synd_o` equals `rd_check_i` XOR the check byte recomputed from `rd_data_i`. It is always presented, one clock after the word is applied.
- R3: A zero syndrome raises neither flag, passes `rd_data_i` through unchanged and gives position 0.
- R4: A syndrome equal to the column of data bit d raises CE, inverts data bit d only, and reports position d.
- R5: A syndrome of 1<<j, meaning that check bit j alone flipped, raises CE, passes the data through unchanged and reports position 64+j.
- R6: Any nonzero even-weight syndrome raises UE. This includes 0x03, which is two flipped check bits, and the syndrome of any pair of flipped data bits.
- R7: An odd-weight syndrome that matches no column, such as 0x7f or 0x07, raises UE and passes the data through uncorrected.
- R8: CE and UE are never high together, and the position output is 0 whenever CE is low.
- R9: While `rst_n` is low at a rising clock edge, every registered decoder output is cleared to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the decoder output register |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data_i | input | 64 | Data to be written |
| wr_check_o | output | 8 | Check byte for `wr_data_i` |
| rd_data_i | input | 64 | Data bits of the word read back |
| rd_check_i | input | 8 | Stored check bits of the word read back |
| dec_data_o | output | 64 | Corrected read data |
| dec_synd_o | output | 8 | Syndrome |
| dec_ce_o | output | 1 | Single-bit error corrected |
| dec_ue_o | output | 1 | Uncorrectable error |
| dec_pos_o | output | 7 | Corrected bit: 0 to 63 for data, 64 to 71 for check bits |

## Verification
The write-side generator and the read-side decoder are independent and work in the same cycle. The bench drives a fresh write word alongside every read word and judges `wr_check_o` combinationally while the registered decode result of the previous read word is checked. Each read word is built from the bench's own reference encoding and then altered by deliberate flips. These cover every single data and check position, data pairs, the 0x03 check pair, and unmatched odd-weight syndromes. The bench predicts the syndrome, the flags, the position and the data for each word and compares all of them on every clock.

// File: rtl/secded_pkg.sv
// Package: shared widths and the fixed parity-check column table.
// Assumes: 64 data bits, 8 check bits, all data columns distinct, odd weight.
package secded_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int POS_W  = $clog2(DATA_W + CHK_W);

    // Column (syndrome signature) of one data bit.
    function automatic logic [CHK_W-1:0] col_of(input int unsigned idx);
        logic [CHK_W-1:0] c;
        case (idx)
            0:  c = 8'hf4;  1:  c = 8'hf1;  2:  c = 8'hec;  3:  c = 8'hea;
            4:  c = 8'he9;  5:  c = 8'he6;  6:  c = 8'he5;  7:  c = 8'he3;
            8:  c = 8'hdc;  9:  c = 8'hda;  10: c = 8'hd9;  11: c = 8'hd6;
            12: c = 8'hd5;  13: c = 8'hd3;  14: c = 8'hce;  15: c = 8'hcb;
            16: c = 8'hb5;  17: c = 8'hb0;  18: c = 8'had;  19: c = 8'hab;
            20: c = 8'ha8;  21: c = 8'ha7;  22: c = 8'ha4;  23: c = 8'ha2;
            24: c = 8'h9d;  25: c = 8'h9b;  26: c = 8'h98;  27: c = 8'h97;
            28: c = 8'h94;  29: c = 8'h92;  30: c = 8'h8f;  31: c = 8'h8a;
            32: c = 8'h75;  33: c = 8'h70;  34: c = 8'h6d;  35: c = 8'h6b;
            36: c = 8'h68;  37: c = 8'h67;  38: c = 8'h64;  39: c = 8'h62;
            40: c = 8'h5e;  41: c = 8'h5b;  42: c = 8'h58;  43: c = 8'h57;
            44: c = 8'h54;  45: c = 8'h52;  46: c = 8'h4f;  47: c = 8'h4a;
            48: c = 8'h34;  49: c = 8'h31;  50: c = 8'h2c;  51: c = 8'h2a;
            52: c = 8'h29;  53: c = 8'h26;  54: c = 8'h25;  55: c = 8'h23;
            56: c = 8'h1c;  57: c = 8'h1a;  58: c = 8'h19;  59: c = 8'h16;
            60: c = 8'h15;  61: c = 8'h13;  62: c = 8'h0e;  63: c = 8'h0b;
            default: c = '0;
        endcase
        return c;
    endfunction

    // Set of data bits that feed check bit j.
    function automatic logic [DATA_W-1:0] row_mask(input int unsigned j);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0]  c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c    = col_of(i);
            m[i] = c[j];
        end
        return m;
    endfunction
endpackage

// File: rtl/secded_enc.sv
// Module: check-byte generator.
// Does: one XOR tree per check bit over the data bits in that matrix row.
// Assumes: purely combinational; used for both writing and recomputing.
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    for (genvar j = 0; j < CHK_W; j++) begin : g_row
        localparam logic [DATA_W-1:0] ROW = row_mask(j);
        // Parity of the data bits selected by row j.
        assign chk_o[j] = ^(data_i & ROW);
    end
endmodule

// File: rtl/secded_corr.sv
// Module: syndrome classifier and single-bit corrector.
// Does: matches the syndrome against every column, repairs a data hit,
//       reports position, and flags anything nonzero and unmatched as UE.
// Assumes: columns are unique, so at most one comparator fires.
module secded_corr
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  synd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ce_o,
    output logic              ue_o,
    output logic [POS_W-1:0]  pos_o
);
    logic [DATA_W-1:0] hit_d;
    logic [CHK_W-1:0]  hit_c;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dcmp
        localparam logic [CHK_W-1:0] COL = col_of(i);
        // Compare syndrome with data column i.
        assign hit_d[i] = (synd_i == COL);
    end
    for (genvar j = 0; j < CHK_W; j++) begin : g_ccmp
        // Compare syndrome with the one-hot column of check bit j.
        assign hit_c[j] = (synd_i == CHK_W'(1 << j));
    end

    // Repair the data bit that matched, if any.
    assign data_o = data_i ^ hit_d;
    // Classify: any match is correctable, nonzero without match is not.
    assign ce_o   = |{hit_c, hit_d};
    assign ue_o   = (synd_i != '0) && !(|{hit_c, hit_d});

    // Encode the matching position: data 0..63, check bits after them.
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < DATA_W; i++)
            if (hit_d[i]) pos_o = POS_W'(i);
        for (int j = 0; j < CHK_W; j++)
            if (hit_c[j]) pos_o = POS_W'(DATA_W + j);
    end

    // At most one column may match one syndrome.
    always_comb begin
        assert_unique_match_R4: assert ($onehot0({hit_c, hit_d}));
    end
endmodule

// File: rtl/secded_codec.sv
// Module: SECDED 72/64 codec top.
// Does: combinational check-byte generation for writes; syndrome, correction
//       and classification for reads, registered when REG_OUT is set.
// Assumes: synchronous active-low reset; one new read word per clock.
module secded_codec
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       wr_data_i,
    output logic [7:0]        wr_check_o,
    input  logic [63:0]       rd_data_i,
    input  logic [7:0]        rd_check_i,
    output logic [63:0]       dec_data_o,
    output logic [7:0]        dec_synd_o,
    output logic              dec_ce_o,
    output logic              dec_ue_o,
    output logic [6:0]        dec_pos_o
);
    logic [CHK_W-1:0]  rd_recalc;
    logic [CHK_W-1:0]  synd;
    logic [DATA_W-1:0] fix_data;
    logic              fix_ce;
    logic              fix_ue;
    logic [POS_W-1:0]  fix_pos;

    secded_enc u_wr_enc (.data_i(wr_data_i), .chk_o(wr_check_o));
    secded_enc u_rd_enc (.data_i(rd_data_i), .chk_o(rd_recalc));

    // Syndrome: stored check byte against the recomputed one.
    assign synd = rd_check_i ^ rd_recalc;

    secded_corr u_corr (
        .data_i (rd_data_i),
        .synd_i (synd),
        .data_o (fix_data),
        .ce_o   (fix_ce),
        .ue_o   (fix_ue),
        .pos_o  (fix_pos)
    );

    if (REG_OUT) begin : g_reg
        // Output register: one-cycle decode latency, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dec_data_o <= '0;
                dec_synd_o <= '0;
                dec_ce_o   <= 1'b0;
                dec_ue_o   <= 1'b0;
                dec_pos_o  <= '0;
            end else begin
                dec_data_o <= fix_data;
                dec_synd_o <= synd;
                dec_ce_o   <= fix_ce;
                dec_ue_o   <= fix_ue;
                dec_pos_o  <= fix_pos;
            end
        end

        assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(dec_ce_o && dec_ue_o));
        assert_pos_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_ce_o |-> dec_pos_o == '0);
        assert_clean_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && dec_synd_o == '0 |->
                !dec_ce_o && !dec_ue_o && dec_data_o == $past(rd_data_i));
        assert_one_fix_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && dec_ce_o && dec_pos_o < 7'd64 |->
                $countones(dec_data_o ^ $past(rd_data_i)) == 1);
        assert_chk_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && dec_ce_o && dec_pos_o >= 7'd64 |->
                dec_data_o == $past(rd_data_i));
        assert_ue_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && dec_ue_o |-> dec_data_o == $past(rd_data_i));
        assert_ce_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
            dec_ce_o |-> $countones(dec_synd_o) % 2 == 1);
    end else begin : g_comb
        // Bypass: results straight from the combinational decoder.
        always_comb begin
            dec_data_o = fix_data;
            dec_synd_o = synd;
            dec_ce_o   = fix_ce;
            dec_ue_o   = fix_ue;
            dec_pos_o  = fix_pos;
        end
    end
endmodule

// File: tb/test_secded_codec.sv
module test_secded_codec;
    localparam logic [7:0] TBL [64] = '{
        8'hf4,8'hf1,8'hec,8'hea,8'he9,8'he6,8'he5,8'he3,
        8'hdc,8'hda,8'hd9,8'hd6,8'hd5,8'hd3,8'hce,8'hcb,
        8'hb5,8'hb0,8'had,8'hab,8'ha8,8'ha7,8'ha4,8'ha2,
        8'h9d,8'h9b,8'h98,8'h97,8'h94,8'h92,8'h8f,8'h8a,
        8'h75,8'h70,8'h6d,8'h6b,8'h68,8'h67,8'h64,8'h62,
        8'h5e,8'h5b,8'h58,8'h57,8'h54,8'h52,8'h4f,8'h4a,
        8'h34,8'h31,8'h2c,8'h2a,8'h29,8'h26,8'h25,8'h23,
        8'h1c,8'h1a,8'h19,8'h16,8'h15,8'h13,8'h0e,8'h0b};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_check;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_check = '0;
    logic [63:0] dec_data;
    logic [7:0]  dec_synd;
    logic        dec_ce, dec_ue;
    logic [6:0]  dec_pos;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    secded_codec i_secded_codec (
        .clk(clk), .rst_n(rst_n),
        .wr_data_i(wr_data), .wr_check_o(wr_check),
        .rd_data_i(rd_data), .rd_check_i(rd_check),
        .dec_data_o(dec_data), .dec_synd_o(dec_synd),
        .dec_ce_o(dec_ce), .dec_ue_o(dec_ue), .dec_pos_o(dec_pos));

    // Reference encoder: loop over columns.
    function automatic logic [7:0] ref_enc(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++) if (d[i]) c ^= TBL[i];
        return c;
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one read word plus one write word, then judge both.
    task automatic apply(input logic [63:0] d, input logic [7:0] chk,
                         input logic [63:0] wd, input string req);
        logic [7:0]  s;
        logic [63:0] ed;
        logic        ece, eue;
        logic [6:0]  epos;
        @(negedge clk);
        rd_data = d; rd_check = chk; wr_data = wd;
        #1;
        cmp("R1", "wr_check", 64'(wr_check), 64'(ref_enc(wd)));
        s = chk ^ ref_enc(d);
        ed = d; ece = 0; eue = 0; epos = '0;
        if (s != 0) begin
            for (int i = 0; i < 64; i++)
                if (TBL[i] == s) begin ed[i] = ~ed[i]; ece = 1; epos = 7'(i); end
            for (int j = 0; j < 8; j++)
                if (s == 8'(1 << j)) begin ece = 1; epos = 7'(64 + j); end
            eue = !ece;
        end
        @(posedge clk);
        #1;
        cmp("R2", "synd", 64'(dec_synd), 64'(s));
        cmp(req, "data", dec_data, ed);
        cmp(req, "ce", 64'(dec_ce), 64'(ece));
        cmp(req, "ue", 64'(dec_ue), 64'(eue));
        cmp("R8", "pos", 64'(dec_pos), 64'(epos));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        logic [63:0] d;
        // R9: reset clears outputs.
        rd_data = '1; rd_check = 8'h5a;
        repeat (2) @(posedge clk);
        #1;
        cmp("R9", "rst data", dec_data, 64'd0);
        cmp("R9", "rst flags", 64'({dec_ce, dec_ue, dec_pos, dec_synd}), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        // R3 / R1: clean words, incl. all-zero and all-one.
        apply(64'd0, ref_enc(64'd0), 64'd0, "R3");
        apply('1, ref_enc('1), '1, "R3");
        for (int k = 0; k < 20; k++) begin
            d = rnd64();
            apply(d, ref_enc(d), rnd64(), "R3");
        end
        // R4: every single data bit flip.
        for (int i = 0; i < 64; i++) begin
            d = rnd64();
            apply(d ^ (64'd1 << i), ref_enc(d), rnd64(), "R4");
        end
        // R5: every single check bit flip.
        for (int j = 0; j < 8; j++) begin
            d = rnd64();
            apply(d, ref_enc(d) ^ 8'(1 << j), rnd64(), "R5");
        end
        // R6: two check bits (syndrome 0x03) and data pairs.
        d = rnd64();
        apply(d, ref_enc(d) ^ 8'h03, rnd64(), "R6");
        for (int k = 0; k < 30; k++) begin
            int a = k % 64;
            int b = (k * 7 + 1 + k) % 64;
            if (a == b) b = (b + 1) % 64;
            d = rnd64();
            apply(d ^ (64'd1 << a) ^ (64'd1 << b), ref_enc(d), rnd64(), "R6");
        end
        d = rnd64();
        apply(d ^ 64'd1, ref_enc(d) ^ 8'h01, rnd64(), "R6");
        // R7: unmatched odd-weight syndromes.
        d = rnd64();
        apply(d, ref_enc(d) ^ 8'h7f, rnd64(), "R7");
        d = rnd64();
        apply(d, ref_enc(d) ^ 8'h07, rnd64(), "R7");
        d = rnd64();
        apply(d, ref_enc(d) ^ 8'hfe, rnd64(), "R7");
        // R9 again: mid-run reset.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        cmp("R9", "mid rst", 64'({dec_ce, dec_ue, dec_pos, dec_synd}) | dec_data, 64'd0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule